// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge

This block gathers up to 32 level-sensitive peripheral request lines into one interrupt line for a processor. Each source has a bit in a mask register. A configuration register holds a global enable, a programmable top-priority source and a three-bit request level. The request level is driven out next to the interrupt line. Among the unmasked sources that are asserted, one fixed order picks the winner. In that order the higher vector number ranks higher, and the programmed top-priority source outranks every other source.

Software takes an interrupt by writing the acknowledge bit of the vector register and then reading that register. The write latches the winning vector number and marks that vector as in service. The number then stays readable until the next acknowledge. A source in service holds off any source of equal or lower rank until software writes a one to its in-service bit. If nothing is eligible at the acknowledge, for example because the request was masked or dropped after the line was raised, the controller hands out a reserved error vector. It sets no in-service bit in that case.

Top module: `vic_top`

## Requirements
- R1: After a synchronous active-low reset the configuration, mask and in-service registers and the vector field all read zero, and `irq` is low.
- R2: The mask register sits at address 1, with bit n controlling source n: 1 enables the source and 0 masks it. A masked source never raises `irq`.
- R3: Configuration bit 7 (address 0) is the global enable. While it is 0, `irq` stays low whatever the sources do.
- R4: A write to address 3 with bit 0 set is an acknowledge. A later read of address 3 returns the latched vector number in bits 15:11, with every other bit zero.
- R5: When several enabled sources request at once, the source with the highest vector number wins.
- R6: Configuration bits 12:8 name a top-priority source. When that source is requesting and enabled, it wins over every other source. The value 0 names the error vector and so gives no override.
- R7: An acknowledge sets the in-service bit of the winning vector. The vector field then holds its value until the next acknowledge, however the sources change.
- R8: The in-service register sits at address 2 and is write-one-to-clear. Writing 1 at bit n ends service of vector n, and bits written as 0 are left unchanged.
- R9: `irq` asserts only when the global enable is set and an enabled requesting source ranks strictly above every vector in service.
- R10: An acknowledge with no eligible source returns the error vector 0 and changes no in-service bit. Source line 0 is reserved for this vector and is ignored.
- R11: Requests are level-sensitive. A source stays pending while its line is high, and its request is gone once the line falls.
- R12: Configuration bits 15:13 are driven unchanged on `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 32 | Level-sensitive request lines, one per vector |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Interrupt line to the processor |
| irq_level | output | 3 | Programmed request level |

## Verification
The selection logic is driven with three source sets: a single source, several simultaneous sources, and sources that include the programmed top-priority vector. The first separates the masked case from the unmasked one. The second checks that the highest number wins. The third checks that the override beats the natural order. Nested service is tested by raising a source below, equal to and above the one in service, which shows whether blocking uses the rank and includes the equal case. Acknowledges made with nothing requesting, and with the only request masked, must both give the error vector and leave the in-service register untouched.

// File: rtl/vic_pkg.sv
// Shared constants for the vectored interrupt controller.
// Assumes a two-bit register address space and a 32-bit data bus.
package vic_pkg;
    localparam int unsigned NUM_SRC  = 32;
    localparam int unsigned VEC_W    = $clog2(NUM_SRC);
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] A_CFG   = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK  = 2'd1;
    localparam logic [ADDR_W-1:0] A_INSVC = 2'd2;
    localparam logic [ADDR_W-1:0] A_VEC   = 2'd3;

    // Configuration field positions
    localparam int unsigned CFG_LVL_HI = 15;
    localparam int unsigned CFG_LVL_LO = 13;
    localparam int unsigned CFG_TOP_HI = 12;
    localparam int unsigned CFG_TOP_LO = 8;
    localparam int unsigned CFG_GIE    = 7;

    // Vector register: number in 15:11, acknowledge strobe at bit 0
    localparam int unsigned VEC_FLD_LO = 11;
    localparam int unsigned ACK_BIT    = 0;

    localparam logic [VEC_W-1:0] ERR_VEC = '0;
endpackage

// File: rtl/vic_pick.sv
// Finds the highest-ranked set bit in a request vector.
// The rank of a vector is its own number, except the programmed top
// source, whose rank is NUM (above all). Pure combinational logic.
module vic_pick #(
    parameter int unsigned NUM   = 32,
    parameter int unsigned IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   req,
    input  logic [IDX_W-1:0] top_idx,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W:0]   rank
);
    logic [IDX_W-1:0] high_idx;
    logic             override;

    // Scan upward so the last set bit seen is the highest number
    always_comb begin
        found    = 1'b0;
        high_idx = '0;
        for (int i = 0; i < NUM; i++) begin
            if (req[i]) begin
                found    = 1'b1;
                high_idx = IDX_W'(i);
            end
        end
    end

    // Apply the programmed override and form the comparable rank
    always_comb begin
        override = req[top_idx];
        idx      = override ? top_idx : high_idx;
        rank     = override ? (IDX_W+1)'(NUM) : {1'b0, high_idx};
    end
endmodule

// File: rtl/vic_regs.sv
// Register file and bus decode for the interrupt controller.
// Holds configuration, mask, in-service and latched vector.
// Assumes single-cycle accesses; read data is combinational.
module vic_regs
    import vic_pkg::*;
#(
    parameter int unsigned NUM   = NUM_SRC,
    parameter int unsigned IDX_W = $clog2(NUM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eligible,
    input  logic [IDX_W-1:0]  win_idx,
    output logic              gie,
    output logic [2:0]        level,
    output logic [IDX_W-1:0]  top_idx,
    output logic [NUM-1:0]    mask_q,
    output logic [NUM-1:0]    isr_q,
    output logic [IDX_W-1:0]  vec_q,
    output logic              ack_wr
);
    localparam int unsigned CFG_W = CFG_LVL_HI + 1;

    logic [CFG_W-1:0] cfg_q;
    logic             wr_cfg, wr_mask, wr_isr;
    logic [NUM-1:0]   isr_set;

    // Decode write strobes
    always_comb begin
        wr_cfg  = bus_req && bus_we && (bus_addr == A_CFG);
        wr_mask = bus_req && bus_we && (bus_addr == A_MASK);
        wr_isr  = bus_req && bus_we && (bus_addr == A_INSVC);
        ack_wr  = bus_req && bus_we && (bus_addr == A_VEC) && bus_wdata[ACK_BIT];
    end

    // Unpack configuration fields
    always_comb begin
        gie     = cfg_q[CFG_GIE];
        level   = cfg_q[CFG_LVL_HI:CFG_LVL_LO];
        top_idx = cfg_q[CFG_TOP_HI:CFG_TOP_LO];
    end

    // One-hot in-service set for the winner of an acknowledge
    always_comb begin
        isr_set = '0;
        if (ack_wr && eligible) isr_set[win_idx] = 1'b1;
    end

    // Configuration register (only defined fields are stored)
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_cfg) begin
            cfg_q                       <= '0;
            cfg_q[CFG_LVL_HI:CFG_LVL_LO] <= bus_wdata[CFG_LVL_HI:CFG_LVL_LO];
            cfg_q[CFG_TOP_HI:CFG_TOP_LO] <= bus_wdata[CFG_TOP_HI:CFG_TOP_LO];
            cfg_q[CFG_GIE]               <= bus_wdata[CFG_GIE];
        end
    end

    // Per-source mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= bus_wdata[NUM-1:0];
    end

    // In-service register: set on acknowledge, clear on write-one
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr_q <= '0;
        else if (wr_isr)
            isr_q <= isr_q & ~bus_wdata[NUM-1:0];
        else
            isr_q <= isr_q | isr_set;
    end

    // Latched vector: winner or error vector, frozen between acknowledges
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= ERR_VEC;
        else if (ack_wr)
            vec_q <= eligible ? win_idx : ERR_VEC;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            case (bus_addr)
                A_CFG:   bus_rdata[CFG_W-1:0] = cfg_q;
                A_MASK:  bus_rdata[NUM-1:0]   = mask_q;
                A_INSVC: bus_rdata[NUM-1:0]   = isr_q;
                default: bus_rdata[VEC_FLD_LO +: IDX_W] = vec_q;
            endcase
        end
    end
endmodule

// File: rtl/vic_top.sv
// Vectored interrupt controller top level.
// Combines masked level requests, ranks them against the vectors in
// service and drives one interrupt line. Sources are assumed to be
// synchronous to clk.
module vic_top
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_req,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [2:0]        irq_level
);
    logic             gie, ack_wr, eligible;
    logic [VEC_W-1:0] top_idx, vec_q, p_idx, s_idx;
    logic [NUM_SRC-1:0] mask_q, isr_q, eff_req, err_keep;
    logic             p_found, s_found;
    logic [VEC_W:0]   p_rank, s_rank;

    // Source line of the error vector is reserved and never requests
    always_comb begin
        err_keep          = '1;
        err_keep[ERR_VEC] = 1'b0;
        eff_req           = src_req & mask_q & err_keep;
    end

    vic_regs #(.NUM(NUM_SRC), .IDX_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eligible(eligible), .win_idx(p_idx),
        .gie(gie), .level(irq_level), .top_idx(top_idx),
        .mask_q(mask_q), .isr_q(isr_q), .vec_q(vec_q), .ack_wr(ack_wr)
    );

    vic_pick #(.NUM(NUM_SRC), .IDX_W(VEC_W)) u_pick_pend (
        .req(eff_req), .top_idx(top_idx),
        .found(p_found), .idx(p_idx), .rank(p_rank)
    );

    vic_pick #(.NUM(NUM_SRC), .IDX_W(VEC_W)) u_pick_svc (
        .req(isr_q), .top_idx(top_idx),
        .found(s_found), .idx(s_idx), .rank(s_rank)
    );

    // Winner must outrank every vector in service
    always_comb begin
        eligible = p_found && (!s_found || (p_rank > s_rank));
        irq      = gie && eligible;
    end
endmodule

// File: rtl/vic_chk.sv
// Property checker for vic_top, attached with bind.
module vic_chk
    import vic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               gie,
    input logic               irq,
    input logic [31:0]        src_req,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] isr_q,
    input logic [VEC_W-1:0]   vec_q,
    input logic               ack_wr,
    input logic               eligible,
    input logic               bus_req,
    input logic               bus_we,
    input logic [1:0]         bus_addr,
    input logic [31:0]        bus_wdata
);
    // R3: line held low without global enable
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);

    // R2: line only with an enabled requesting source
    p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((src_req & mask_q) != '0));

    // R8: written ones are cleared next cycle
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == A_INSVC) |=> ((isr_q & $past(bus_wdata)) == '0));

    // R7: acknowledged real vector is in service
    p_ack_svc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> (vec_q == ERR_VEC) || isr_q[vec_q]);

    // R7: vector frozen between acknowledges
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> $stable(vec_q));

    // R10: failed acknowledge leaves in-service untouched
    p_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !eligible) |=> $stable(isr_q));
endmodule

bind vic_top vic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gie(gie), .irq(irq), .src_req(src_req),
    .mask_q(mask_q), .isr_q(isr_q), .vec_q(vec_q), .ack_wr(ack_wr),
    .eligible(eligible), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_vic_top.sv
module test_vic_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_req;
    logic        bus_req, bus_we;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [2:0]  irq_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vic_top i_vic_top (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .irq_level(irq_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] s);
        @(negedge clk);
        src_req = s;
        #2;
    endtask

    task automatic ack_vec(output logic [31:0] d);
        wr(2'd3, 32'h1);
        rd(2'd3, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); check("R1 cfg", d, 0);
        rd(2'd1, d); check("R1 mask", d, 0);
        rd(2'd2, d); check("R1 insvc", d, 0);
        rd(2'd3, d); check("R1 vec", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_mask_gate;
        set_src(32'h20);
        wr(2'd0, 32'h80);
        #2 check("R2 masked src", {31'b0, irq}, 0);
        wr(2'd1, 32'h20);
        #2 check("R2 enabled src", {31'b0, irq}, 1);
        wr(2'd0, 32'h0);
        #2 check("R3 no global enable", {31'b0, irq}, 0);
        wr(2'd0, 32'h80);
        set_src(32'h0);
        check("R11 dropped line", {31'b0, irq}, 0);
    endtask

    task automatic t_order_nest;
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        set_src((32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20));
        check("R11 held lines pend", {31'b0, irq}, 1);
        ack_vec(d);
        check("R4 R5 vector 20", d, 32'd20 << 11);
        rd(2'd2, d); check("R7 insvc 20", d, 32'h1 << 20);
        check("R9 equal or lower blocked", {31'b0, irq}, 0);
        set_src((32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20) | (32'h1 << 25));
        check("R9 higher preempts", {31'b0, irq}, 1);
        ack_vec(d);
        check("R5 vector 25", d, 32'd25 << 11);
        set_src(32'h0);
        rd(2'd3, d); check("R7 vector frozen", d, 32'd25 << 11);
        rd(2'd2, d); check("R7 insvc 20 25", d, (32'h1 << 20) | (32'h1 << 25));
        wr(2'd2, 32'h1 << 25);
        rd(2'd2, d); check("R8 clear 25", d, 32'h1 << 20);
        wr(2'd2, 32'h0);
        rd(2'd2, d); check("R8 zero write no effect", d, 32'h1 << 20);
        wr(2'd2, 32'h1 << 20);
        rd(2'd2, d); check("R8 clear 20", d, 0);
    endtask

    task automatic t_override;
        logic [31:0] d;
        wr(2'd0, 32'h80 | (32'd9 << 8) | (32'd5 << 13));
        check("R12 level out", {29'b0, irq_level}, 5);
        set_src((32'h1 << 9) | (32'h1 << 20));
        ack_vec(d);
        check("R6 override wins", d, 32'd9 << 11);
        check("R6 top source blocks 20", {31'b0, irq}, 0);
        wr(2'd2, 32'h1 << 9);
        wr(2'd0, 32'h80);
        set_src(32'h0);
    endtask

    task automatic t_error;
        logic [31:0] d;
        ack_vec(d);
        check("R10 nothing pending", d, 0);
        rd(2'd2, d); check("R10 insvc untouched", d, 0);
        wr(2'd1, 32'h0);
        set_src(32'h8);
        ack_vec(d);
        check("R10 masked request", d, 0);
        wr(2'd1, 32'hFFFF_FFFF);
        set_src(32'h1);
        check("R10 line 0 ignored", {31'b0, irq}, 0);
        ack_vec(d);
        rd(2'd2, d); check("R10 line 0 no insvc", d, 0);
    endtask

    initial begin
        rst_n = 1'b0; src_req = '0; bus_req = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_mask_gate();
        t_order_nest();
        t_override();
        t_error();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule